// File: doc/BRIEF.md
# Two-Level Address Translator with Translation Cache

This block turns 32-bit virtual addresses into physical addresses. A four-entry, fully associative translation cache is searched first. When it misses, a hardware walker reads a two-level page table from memory and loads the resulting leaf into the cache. It then repeats the lookup, and only that repeated lookup applies the access-permission check. Every request ends with one response: a physical address, a page fault or a protection fault.

The level-1 table is found through a root page number input, which the operating system reloads whenever the active process changes. The walker reads page-table words through a read port that takes physical addresses as they are, with no translation. Requests use a valid/ready handshake and only one can be in flight. A flush input empties the translation cache.

The controller is a single enumerated state machine. The states are IDLE, LOOKUP, L1_RD, L1_WT, L2_RD, L2_WT and REFILL. The transitions are:
- IDLE to LOOKUP on an accepted request.
- LOOKUP to IDLE on a hit, with a response.
- LOOKUP to L1_RD on a miss.
- L1_RD to L1_WT, and L2_RD to L2_WT, unconditionally.
- L1_WT to L2_RD when the level-1 word is usable, and L1_WT to IDLE with a page fault when it is not.
- L2_WT to REFILL when the leaf is usable, and L2_WT to IDLE with a page fault when it is not.
- REFILL to LOOKUP.

Top module: `mmu_xlate`

## Requirements
- R1: The walk reads the level-1 word at {root_ppn_i, vaddr[31:22], 2'b00} and then the level-2 word at {level-1 page number, vaddr[21:12], 2'b00}. Each read is a one-cycle mem_req_o pulse with a word-aligned address. The root value is taken at the moment the walk starts.
- R2: A page-table word uses this layout: bit 0 means the entry exists, bit 1 means the page is resident in memory, bit 2 allows reads, bit 3 allows writes, bit 4 is the dirty bit, and bits 31:12 hold the page number (physical or disk). At either level, a word with bit 0 or bit 1 clear stops the walk at once. The response then carries rsp_fault_o = 1 (page fault) and address 0, and nothing is loaded into the cache, so the same access walks again.
- R3: A hit in the cache makes no memory read, and rsp_valid_o rises at the first clock edge after the edge that accepted the request.
- R4: After a miss that walks successfully, the leaf is loaded into the cache and the lookup repeats. The response is {leaf page number, vaddr[11:0]} with rsp_fault_o = 0.
- R5: A read of a page without read permission, or a write to a page without write permission, gives rsp_fault_o = 2 (protection fault) and address 0. The translation stays in the cache.
- R6: A successful write sets the dirty bit of the cache entry. rsp_dirty_o reports the entry's dirty bit after the access and is 0 on any fault.
- R7: Entries are replaced in round-robin order across the four slots, starting from slot 0 after reset.
- R8: A one-cycle pulse on flush_i invalidates every entry, so the next access to any page walks again.
- R9: req_ready_o is high only in IDLE, so at most one request is outstanding. rsp_valid_o is a single-cycle pulse. After reset, req_ready_o = 1, rsp_valid_o = 0 and mem_req_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all cached translations |
| root_ppn_i | input | 20 | Page number of the level-1 table |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_dirty_o | output | 1 | Dirty bit of the entry after the access |
| mem_req_o | output | 1 | Page-table read request |
| mem_addr_o | output | 32 | Physical address of the page-table word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page-table word |

## Verification
Round-robin eviction is the hardest behaviour to reach from the ports. The cache is invisible, so a victim can only be seen by counting memory reads on a later access. The stimulus fills three slots, including one with a protection-faulting page that still occupies a slot. It then adds two more pages. The bench checks that the page in slot 1 still hits with zero reads while the page in slot 0 now needs two reads. Page faults at each level are checked with exact read counts, which shows the walk stops early and loads nothing.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int PN_W  = VA_W - OFF_W;

    // page-table word bit positions
    localparam int PTE_EXIST = 0;
    localparam int PTE_RES   = 1;
    localparam int PTE_RD    = 2;
    localparam int PTE_WR    = 3;
    localparam int PTE_DIRTY = 4;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2,
        FLT_RSVD = 2'd3
    } fault_e;

    typedef struct packed {
        logic            vld;
        logic            rd;
        logic            wr;
        logic            dirty;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] ppn;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_L1_RD,
        ST_L1_WT,
        ST_L2_RD,
        ST_L2_WT,
        ST_REFILL
    } xlt_state_e;
endpackage

// File: rtl/xlt_pte_dec.sv
module xlt_pte_dec
    import xlt_pkg::*;
(
    input  logic [VA_W-1:0] pte,
    output logic            usable,
    output logic [PN_W-1:0] pn,
    output logic            rd,
    output logic            wr,
    output logic            dirty
);
    // a word points somewhere usable only when it exists and is in memory
    always_comb begin
        usable = pte[PTE_EXIST] & pte[PTE_RES];
        pn     = pte[VA_W-1:OFF_W];
        rd     = pte[PTE_RD];
        wr     = pte[PTE_WR];
        dirty  = pte[PTE_DIRTY];
    end
endmodule

// File: rtl/xlt_perm.sv
module xlt_perm
    import xlt_pkg::*;
(
    input  logic   ent_rd,
    input  logic   ent_wr,
    input  logic   ent_dirty,
    input  logic   is_write,
    output fault_e flt,
    output logic   dirty_nxt
);
    always_comb begin
        flt = FLT_NONE;
        if (is_write && !ent_wr) begin
            flt = FLT_PROT;
        end else if (!is_write && !ent_rd) begin
            flt = FLT_PROT;
        end
        dirty_nxt = (flt == FLT_NONE) ? (ent_dirty | is_write) : 1'b0;
    end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
    import xlt_pkg::*;
#(
    parameter  int ENTRIES = 4,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_vpn,
    output logic            lk_hit,
    output logic [IW-1:0]   lk_idx,
    output tlb_ent_t        lk_ent,
    input  logic            fill_en,
    input  tlb_ent_t        fill_ent,
    input  logic            mark_en,
    input  logic [IW-1:0]   mark_idx
);
    tlb_ent_t          ents [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IW-1:0]      rr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents[g].vld && (ents[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) lk_idx = IW'(i);
        end
        lk_hit = |match;
        lk_ent = ents[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
            rr_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) ents[i].vld <= 1'b0;
        end else begin
            if (fill_en) begin
                ents[rr_q] <= fill_ent;
                rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
            if (mark_en) begin
                ents[mark_idx].dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import xlt_pkg::*;
#(
    parameter  int ENTRIES = 4,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic [PN_W-1:0] root_ppn_i,
    input  logic            req_valid_i,
    output logic            req_ready_o,
    input  logic [VA_W-1:0] req_vaddr_i,
    input  logic            req_write_i,
    output logic            rsp_valid_o,
    output logic [VA_W-1:0] rsp_paddr_o,
    output logic [1:0]      rsp_fault_o,
    output logic            rsp_dirty_o,
    output logic            mem_req_o,
    output logic [VA_W-1:0] mem_addr_o,
    input  logic            mem_rvalid_i,
    input  logic [VA_W-1:0] mem_rdata_i
);
    xlt_state_e state_q, state_d;

    logic [VA_W-1:0] va_q;
    logic            wr_q;
    logic [PN_W-1:0] l1_pn_q;
    logic [PN_W-1:0] leaf_pn_q;
    logic            leaf_rd_q, leaf_wr_q, leaf_dirty_q;

    logic            rsp_valid_q;
    logic [VA_W-1:0] rsp_paddr_q;
    fault_e          rsp_fault_q;
    logic            rsp_dirty_q;

    logic            hit;
    logic [IW-1:0]   hit_idx;
    tlb_ent_t        hit_ent;
    tlb_ent_t        fill_ent;
    logic            fill_en, mark_en;

    logic            pte_ok, pte_rd, pte_wr, pte_dirty;
    logic [PN_W-1:0] pte_pn;

    fault_e          perm_flt;
    logic            perm_dirty;

    xlt_tlb #(.ENTRIES(ENTRIES)) tlb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_i),
        .lk_vpn   (va_q[VA_W-1:OFF_W]),
        .lk_hit   (hit),
        .lk_idx   (hit_idx),
        .lk_ent   (hit_ent),
        .fill_en  (fill_en),
        .fill_ent (fill_ent),
        .mark_en  (mark_en),
        .mark_idx (hit_idx)
    );

    xlt_pte_dec pte_i (
        .pte    (mem_rdata_i),
        .usable (pte_ok),
        .pn     (pte_pn),
        .rd     (pte_rd),
        .wr     (pte_wr),
        .dirty  (pte_dirty)
    );

    xlt_perm perm_i (
        .ent_rd    (hit_ent.rd),
        .ent_wr    (hit_ent.wr),
        .ent_dirty (hit_ent.dirty),
        .is_write  (wr_q),
        .flt       (perm_flt),
        .dirty_nxt (perm_dirty)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit ? ST_IDLE : ST_L1_RD;
            ST_L1_RD:  state_d = ST_L1_WT;
            ST_L1_WT:  if (mem_rvalid_i) state_d = pte_ok ? ST_L2_RD : ST_IDLE;
            ST_L2_RD:  state_d = ST_L2_WT;
            ST_L2_WT:  if (mem_rvalid_i) state_d = pte_ok ? ST_REFILL : ST_IDLE;
            ST_REFILL: state_d = ST_LOOKUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // combinational outputs
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        mem_req_o   = (state_q == ST_L1_RD) || (state_q == ST_L2_RD);
        mem_addr_o  = '0;
        if (state_q == ST_L1_RD) begin
            mem_addr_o = {root_ppn_i, va_q[VA_W-1:VA_W-IDX_W], 2'b00};
        end else if (state_q == ST_L2_RD) begin
            mem_addr_o = {l1_pn_q, va_q[VA_W-IDX_W-1:OFF_W], 2'b00};
        end
        fill_en      = (state_q == ST_REFILL);
        fill_ent.vld = 1'b1;
        fill_ent.rd  = leaf_rd_q;
        fill_ent.wr  = leaf_wr_q;
        fill_ent.dirty = leaf_dirty_q;
        fill_ent.vpn = va_q[VA_W-1:OFF_W];
        fill_ent.ppn = leaf_pn_q;
        mark_en = (state_q == ST_LOOKUP) && hit && wr_q &&
                  (perm_flt == FLT_NONE) && !hit_ent.dirty;
    end

    // datapath and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            l1_pn_q      <= '0;
            leaf_pn_q    <= '0;
            leaf_rd_q    <= 1'b0;
            leaf_wr_q    <= 1'b0;
            leaf_dirty_q <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_paddr_q  <= '0;
            rsp_fault_q  <= FLT_NONE;
            rsp_dirty_q  <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        va_q <= req_vaddr_i;
                        wr_q <= req_write_i;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= perm_flt;
                        rsp_dirty_q <= perm_dirty;
                        rsp_paddr_q <= (perm_flt == FLT_NONE) ?
                                       {hit_ent.ppn, va_q[OFF_W-1:0]} : '0;
                    end
                end
                ST_L1_WT: begin
                    if (mem_rvalid_i) begin
                        if (pte_ok) begin
                            l1_pn_q <= pte_pn;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= FLT_PAGE;
                            rsp_paddr_q <= '0;
                            rsp_dirty_q <= 1'b0;
                        end
                    end
                end
                ST_L2_WT: begin
                    if (mem_rvalid_i) begin
                        if (pte_ok) begin
                            leaf_pn_q    <= pte_pn;
                            leaf_rd_q    <= pte_rd;
                            leaf_wr_q    <= pte_wr;
                            leaf_dirty_q <= pte_dirty;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= FLT_PAGE;
                            rsp_paddr_q <= '0;
                            rsp_dirty_q <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_paddr_o = rsp_paddr_q;
    assign rsp_fault_o = rsp_fault_q;
    assign rsp_dirty_o = rsp_dirty_q;
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic [31:0] req_vaddr_i,
    input logic        rsp_valid_o,
    input logic [31:0] rsp_paddr_o,
    input logic [1:0]  rsp_fault_o,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o
);
    logic [11:0] off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid_i && req_ready_o) off_q <= req_vaddr_i[11:0];
    end

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R2
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_paddr_o == 32'd0));

    // R2
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_fault_o != 2'd3));

    // R4
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o == 2'd0) |-> (rsp_paddr_o[11:0] == off_q));

    // R1
    pte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R1
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
endmodule

bind mmu_xlate xlt_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_vaddr_i (req_vaddr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/mmu_xlate_tb_top.sv
module mmu_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] root_ppn = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_dirty;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    always #10 clk = ~clk;

    mmu_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .root_ppn_i(root_ppn),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_vaddr_i(req_vaddr), .req_write_i(req_write),
        .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
        .rsp_fault_o(rsp_fault), .rsp_dirty_o(rsp_dirty),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    // page-table memory, two-cycle read latency
    logic [31:0] pmem [logic [31:0]];
    logic        d1;
    logic [31:0] a1;
    int          rd_count = 0;
    logic [31:0] addr_log [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            d1 <= 1'b0;
            a1 <= '0;
            mem_rvalid <= 1'b0;
            mem_rdata <= '0;
        end else begin
            d1 <= mem_req;
            a1 <= mem_addr;
            mem_rvalid <= d1;
            mem_rdata <= pmem.exists(a1) ? pmem[a1] : 32'd0;
            if (mem_req) begin
                rd_count <= rd_count + 1;
                addr_log.push_back(mem_addr);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nerr = 0;
    int done_cnt = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] paddr;
        logic [1:0]  fault;
        logic        dirty;
        int          reads;
        int          base;
        int          lat;
        int          acc;
        string       req;
    } exp_t;
    exp_t exp_q [$];

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "paddr", rsp_paddr, e.paddr);
                chk(e.req, "fault", {30'd0, rsp_fault}, {30'd0, e.fault});
                chk(e.req, "dirty", {31'd0, rsp_dirty}, {31'd0, e.dirty});
                chk(e.req, "memory reads", rd_count - e.base, e.reads);
                if (e.lat >= 0) chk(e.req, "latency", cyc - e.acc, e.lat);
            end
            done_cnt <= done_cnt + 1;
        end
    end

    // driver
    task automatic xact(input logic [31:0] va, input logic wr,
                        input logic [31:0] ep, input logic [1:0] ef,
                        input logic ed, input int er, input int el,
                        input string req);
        exp_t e;
        int   start;
        @(negedge clk);
        chk("R9", "ready while idle", {31'd0, req_ready}, 32'd1);
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        e.paddr = ep; e.fault = ef; e.dirty = ed; e.reads = er;
        e.base = rd_count; e.lat = el; e.req = req;
        start = done_cnt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        e.acc = cyc;
        exp_q.push_back(e);
        chk("R9", "ready low while busy", {31'd0, req_ready}, 32'd0);
        wait (done_cnt != start);
        @(negedge clk);
        chk("R9", "response is one cycle", {31'd0, rsp_valid}, 32'd0);
    endtask

    function automatic logic [31:0] va_of(input int l1, input int l2, input int off);
        return {10'(l1), 10'(l2), 12'(off)};
    endfunction

    function automatic logic [31:0] pte(input logic [19:0] pn, input logic [4:0] fl);
        return {pn, 7'd0, fl};
    endfunction

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // flag values: 1 exists, 2 resident, 4 read, 8 write, 16 dirty
    localparam logic [4:0] F_RW = 5'b01111;
    localparam logic [4:0] F_RO = 5'b00111;
    localparam logic [4:0] F_WO = 5'b01011;
    localparam logic [4:0] F_TB = 5'b00011;

    initial begin
        int n0;
        // root A at 0x10000, level-2 table at 0x20000
        pmem[32'h0001_0004] = pte(20'h00020, F_TB);
        pmem[32'h0001_0008] = 32'd0;
        pmem[32'h0001_000C] = pte(20'h00ABC, 5'b00001);
        pmem[32'h0002_0000] = pte(20'h00100, F_RW);
        pmem[32'h0002_0004] = pte(20'h00101, F_RO);
        pmem[32'h0002_0008] = pte(20'h00102, F_RW);
        pmem[32'h0002_000C] = pte(20'h00103, F_RW);
        pmem[32'h0002_0010] = pte(20'h00104, F_RW);
        pmem[32'h0002_0014] = pte(20'h00555, 5'b00001);
        pmem[32'h0002_001C] = pte(20'h00107, F_WO);
        // root B at 0x30000, level-2 table at 0x40000
        pmem[32'h0003_0004] = pte(20'h00040, F_TB);
        pmem[32'h0004_0000] = pte(20'h00200, F_RW);

        repeat (3) @(negedge clk);
        chk("R9", "reset ready", {31'd0, req_ready}, 32'd1);
        chk("R9", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9", "reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;

        // R4 R1: first access walks
        n0 = addr_log.size();
        xact(va_of(1, 0, 12'h123), 1'b0, 32'h0010_0123, 2'd0, 1'b0, 2, -1, "R4");
        chk("R1", "level-1 address", addr_log[n0], 32'h0001_0004);
        chk("R1", "level-2 address", addr_log[n0+1], 32'h0002_0000);
        // R3: hit
        xact(va_of(1, 0, 12'hABC), 1'b0, 32'h0010_0ABC, 2'd0, 1'b0, 0, 1, "R3");
        // R6: write sets dirty
        xact(va_of(1, 0, 12'h010), 1'b1, 32'h0010_0010, 2'd0, 1'b1, 0, 1, "R6");
        xact(va_of(1, 0, 12'h020), 1'b0, 32'h0010_0020, 2'd0, 1'b1, 0, 1, "R6");
        // R5: write to read-only, translation retained
        xact(va_of(1, 1, 12'h004), 1'b1, 32'd0, 2'd2, 1'b0, 2, -1, "R5");
        xact(va_of(1, 1, 12'h008), 1'b0, 32'h0010_1008, 2'd0, 1'b0, 0, 1, "R5");
        xact(va_of(1, 7, 12'h000), 1'b0, 32'd0, 2'd2, 1'b0, 2, -1, "R5");
        // R2: page faults at each level
        xact(va_of(2, 0, 12'h000), 1'b0, 32'd0, 2'd1, 1'b0, 1, -1, "R2");
        xact(va_of(3, 0, 12'h000), 1'b0, 32'd0, 2'd1, 1'b0, 1, -1, "R2");
        xact(va_of(1, 5, 12'h000), 1'b0, 32'd0, 2'd1, 1'b0, 2, -1, "R2");
        xact(va_of(1, 6, 12'h000), 1'b0, 32'd0, 2'd1, 1'b0, 2, -1, "R2");
        xact(va_of(1, 5, 12'h000), 1'b0, 32'd0, 2'd1, 1'b0, 2, -1, "R2");
        // R7: slots 0..2 hold pages 0,1,7; fill slot 3 then wrap to slot 0
        xact(va_of(1, 2, 12'h000), 1'b0, 32'h0010_2000, 2'd0, 1'b0, 2, -1, "R7");
        xact(va_of(1, 3, 12'h000), 1'b0, 32'h0010_3000, 2'd0, 1'b0, 2, -1, "R7");
        xact(va_of(1, 1, 12'h000), 1'b0, 32'h0010_1000, 2'd0, 1'b0, 0, 1, "R7");
        xact(va_of(1, 0, 12'h000), 1'b0, 32'h0010_0000, 2'd0, 1'b0, 2, -1, "R7");
        xact(va_of(1, 2, 12'h000), 1'b0, 32'h0010_2000, 2'd0, 1'b0, 0, 1, "R7");
        // R8: flush forces a walk
        pulse_flush();
        xact(va_of(1, 2, 12'h000), 1'b0, 32'h0010_2000, 2'd0, 1'b0, 2, -1, "R8");
        // R1: new root after process change
        @(negedge clk);
        root_ppn = 20'h00030;
        pulse_flush();
        n0 = addr_log.size();
        xact(va_of(1, 0, 12'h044), 1'b0, 32'h0020_0044, 2'd0, 1'b0, 2, -1, "R1");
        chk("R1", "new root level-1 address", addr_log[n0], 32'h0003_0004);
        chk("R1", "new root level-2 address", addr_log[n0+1], 32'h0004_0000);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule